// File: doc/BRIEF.md
# Serial Key Clock Access Gate

This block sits beside an asynchronous SRAM-style bus and decides, cycle by cycle, whether the current access belongs to the memory array or to a hidden bank of eight clock registers. It watches the active-low chip-enable, output-enable and write-enable strobes and data line 0, brings them into the local clock domain, and turns each completed bus cycle into a single read event or a single write event.

Access to the clock registers is gained by a serial unlock key of 64 bits. The key travels one bit per ordinary memory write on data line 0, so the unlock writes also land in memory. The key must be preceded by a read, which arms the matcher. Once all 64 bits have matched, the memory is disabled for the next 64 bus cycles. In that window, each read drives one clock bit out on data line 0 and each write takes one bit in. The parallel side of the block takes a snapshot of the eight timekeeper registers when the window opens. It writes a register back only when a whole byte has been written.

Top module: `serial_key_clock_port`

## Requirements
- R1: After reset, `mem_en` is 1, `bus_d0_oe` is 0, no register write is issued, and the matcher is disarmed: a full correct key sent without a preceding read leaves `mem_en` at 1.
- R2: The key is the byte sequence C5h, 3Ah, A3h, 5Ch, C5h, 3Ah, A3h, 5Ch, each byte least-significant bit first. After a read, 64 writes carrying that sequence on `bus_d0_in` drop `mem_en` to 0.
- R3: A write whose data bit differs from the expected key bit freezes the matcher. Later writes, even ones that carry the rest of the key, do not unlock.
- R4: A read at any point before the key completes returns the matcher to the first key bit. Key bits already sent before that read do not count.
- R5: `mem_en` stays 1 through the whole recognition, including the 64th key write. `bus_d0_oe` is never 1 while `mem_en` is 1.
- R6: In the transfer window, each read cycle drives `bus_d0_oe` to 1 while the read strobe is active. `bus_d0_out` carries the snapshot bits in the order bit 0 of register 0 up to bit 7 of register 7. Register k occupies bits 8k+7..8k of `tk_time_in`.
- R7: The snapshot is taken when the last key bit matches. Later changes of `tk_time_in` do not alter the bits read out.
- R8: Each group of eight transfer cycles maps to one register, in order 0 to 7. A group made only of writes issues a one-cycle `tk_wr_en` pulse carrying that index and the byte, assembled least-significant bit first. A group that holds any read issues no write.
- R9: Strobe activity while `bus_ce_n` is 1 is ignored. It does not move the key pointer or the transfer position.
- R10: After the 64th transfer cycle `mem_en` returns to 1 and the matcher is disarmed again, so a new read must precede the next key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Bus chip enable, active low, asynchronous |
| bus_oe_n | input | 1 | Bus output enable, active low, asynchronous |
| bus_we_n | input | 1 | Bus write enable, active low, asynchronous |
| bus_d0_in | input | 1 | Data line 0 as driven by the bus master |
| tk_time_in | input | 64 | Current contents of the eight timekeeper registers, register k in bits 8k+7..8k |
| mem_en | output | 1 | 1 routes the bus cycle to memory, 0 while the clock window is open |
| bus_d0_out | output | 1 | Clock data bit driven on data line 0 |
| bus_d0_oe | output | 1 | Drive enable for `bus_d0_out` |
| tk_wr_en | output | 1 | One-cycle pulse committing a register byte |
| tk_wr_idx | output | 3 | Index of the register being committed |
| tk_wr_data | output | 8 | Byte committed to that register |

## Verification
A strobe edge passes through two synchronizer flops, and the cycle event is taken on the third rising edge. Key pointer, phase, `mem_en` and the register-write pulse therefore settle by the third rising edge after a cycle ends. `bus_d0_oe` and `bus_d0_out` are valid two edges after a read strobe opens. The bench holds every strobe phase for four clock periods and samples at the falling edge that ends that hold, so each result is read at least one edge after it is due. Register-write pulses are caught by a monitor on every rising edge, which the bench then compares against its own byte model.

// File: rtl/skc_pkg.sv
// Shared constants and types for the serial key clock access gate.
// Assumes a 64-bit key split into eight 8-bit clock registers.
package skc_pkg;
    localparam int KEY_BITS = 64;
    localparam int REG_W    = 8;
    localparam int NUM_REGS = KEY_BITS / REG_W;
    localparam int PTR_W    = $clog2(KEY_BITS);
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int GRP_W    = $clog2(REG_W);

    // Bit i is the i-th key bit on the bus (byte 0 in bits 7:0, LSB first).
    localparam logic [KEY_BITS-1:0] UNLOCK_KEY = 64'h5CA3_3AC5_5CA3_3AC5;

    typedef enum logic [1:0] {
        PH_DISARMED = 2'd0,
        PH_HUNT     = 2'd1,
        PH_FROZEN   = 2'd2,
        PH_XFER     = 2'd3
    } phase_t;
endpackage

// File: rtl/skc_strobe_sync.sv
// Synchronizes the asynchronous bus strobes and data bit 0 and emits one
// event pulse at the end of each completed read or write cycle.
// Assumes the master keeps data stable for the whole write strobe.
module skc_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic d0,
    output logic rd_level,
    output logic rd_evt,
    output logic wr_evt,
    output logic wr_bit
);
    localparam logic [3:0] IDLE_RAW = 4'b0111;   // {d0, we_n, oe_n, ce_n}

    logic [3:0] pipe [STAGES];
    logic [3:0] synced;
    logic       ce_act, wr_level;
    logic       rd_q, wr_q, d0_q;

    // Multi-stage synchronizer for strobes and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE_RAW;
        end else begin
            pipe[0] <= {d0, we_n, oe_n, ce_n};
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign synced   = pipe[STAGES-1];
    assign ce_act   = !synced[0];
    assign rd_level = ce_act && !synced[1] && synced[2];
    assign wr_level = ce_act && !synced[2];

    // Delayed levels for end-of-cycle detection; data held during write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= 1'b0;
            wr_q <= 1'b0;
            d0_q <= 1'b0;
        end else begin
            rd_q <= rd_level;
            wr_q <= wr_level;
            if (wr_level) d0_q <= synced[3];
        end
    end

    assign rd_evt = rd_q && !rd_level;
    assign wr_evt = wr_q && !wr_level;
    assign wr_bit = d0_q;

    // R9
    // wr_no_ce_chk
    wr_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_evt |-> $past(ce_act));
    // R9
    // rd_no_ce_chk
    rd_no_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_evt |-> $past(ce_act));
endmodule

// File: rtl/skc_key_matcher.sv
// Tracks the unlock phase: armed by a read, advanced by matching writes,
// frozen by a mismatch, and held in transfer until the shifter finishes.
// Assumes rd_evt and wr_evt are single-cycle pulses.
module skc_key_matcher
    import skc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   rd_evt,
    input  logic   wr_evt,
    input  logic   wr_bit,
    input  logic   xfer_done,
    output phase_t phase,
    output logic   unlock
);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(KEY_BITS - 1);

    logic [PTR_W-1:0] ptr;
    logic             bit_ok;

    assign bit_ok = (wr_bit == UNLOCK_KEY[ptr]);
    assign unlock = (phase == PH_HUNT) && wr_evt && !rd_evt && bit_ok && (ptr == LAST_PTR);

    // Phase and key pointer update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_DISARMED;
            ptr   <= '0;
        end else if (phase == PH_XFER) begin
            if (xfer_done) phase <= PH_DISARMED;
        end else if (rd_evt) begin
            phase <= PH_HUNT;
            ptr   <= '0;
        end else if (wr_evt && phase == PH_HUNT) begin
            if (!bit_ok)           phase <= PH_FROZEN;
            else if (unlock) begin
                phase <= PH_XFER;
                ptr   <= '0;
            end else               ptr <= ptr + 1'b1;
        end
    end

    // R4
    // abort_restart_chk
    abort_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_evt && phase != PH_XFER) |=> (phase == PH_HUNT && ptr == '0));
    // R3
    // frozen_hold_chk
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_FROZEN && !rd_evt) |=> (phase == PH_FROZEN && $stable(ptr)));
    // R2
    // ptr_step_chk
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HUNT && wr_evt && !rd_evt) |=>
            (ptr == PTR_W'($past(ptr) + 1'b1)) || phase == PH_FROZEN || phase == PH_XFER);
    // R10
    // xfer_exit_chk
    xfer_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_XFER && xfer_done) |=> phase == PH_DISARMED);
endmodule

// File: rtl/skc_xfer_shifter.sv
// Holds the 64-bit clock snapshot, rotates it out on reads, shifts bits in
// on writes, and commits a register only after eight consecutive writes.
// Assumes start and active are never high together.
module skc_xfer_shifter
    import skc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                active,
    input  logic                rd_evt,
    input  logic                wr_evt,
    input  logic                wr_bit,
    input  logic [KEY_BITS-1:0] time_in,
    output logic                d0_out,
    output logic                done,
    output logic                wr_en,
    output logic [IDX_W-1:0]    wr_idx,
    output logic [REG_W-1:0]    wr_data
);
    logic [KEY_BITS-1:0] sh;
    logic [PTR_W-1:0]    cnt;
    logic                grp_wr;
    logic                evt, in_bit, grp_end;

    assign evt     = active && (rd_evt || wr_evt);
    assign in_bit  = wr_evt ? wr_bit : sh[0];
    assign grp_end = (cnt[GRP_W-1:0] == '1);
    assign done    = evt && (cnt == '1);
    assign d0_out  = sh[0];

    // Snapshot load, serial shifting and byte commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '0;
            cnt     <= '0;
            grp_wr  <= 1'b1;
            wr_en   <= 1'b0;
            wr_idx  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start) begin
                sh     <= time_in;
                cnt    <= '0;
                grp_wr <= 1'b1;
            end else if (evt) begin
                sh  <= {in_bit, sh[KEY_BITS-1:1]};
                cnt <= cnt + 1'b1;
                if (grp_end) begin
                    grp_wr <= 1'b1;
                    if (grp_wr && wr_evt) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= cnt[PTR_W-1:GRP_W];
                        wr_data <= {wr_bit, sh[KEY_BITS-1 -: REG_W-1]};
                    end
                end else begin
                    grp_wr <= grp_wr && wr_evt;
                end
            end
        end
    end

    // R8
    // commit_boundary_chk
    commit_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (cnt[GRP_W-1:0] == '0));
    // R10
    // done_wrap_chk
    done_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt == '0));
    // R7
    // snap_hold_chk
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !evt) |=> $stable(sh));
endmodule

// File: rtl/serial_key_clock_port.sv
// Top level: routes bus cycles to memory until a 64-bit serial key unlocks
// a 64-cycle serial window onto eight timekeeper registers.
// Assumes the bus strobes are slow relative to clk (several clocks each).
module serial_key_clock_port #(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_ce_n,
    input  logic        bus_oe_n,
    input  logic        bus_we_n,
    input  logic        bus_d0_in,
    input  logic [63:0] tk_time_in,
    output logic        mem_en,
    output logic        bus_d0_out,
    output logic        bus_d0_oe,
    output logic        tk_wr_en,
    output logic [2:0]  tk_wr_idx,
    output logic [7:0]  tk_wr_data
);
    import skc_pkg::*;

    logic   rd_level, rd_evt, wr_evt, wr_bit;
    logic   unlock, xfer_done, in_xfer;
    phase_t phase;

    skc_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n),
        .ce_n(bus_ce_n), .oe_n(bus_oe_n), .we_n(bus_we_n), .d0(bus_d0_in),
        .rd_level(rd_level), .rd_evt(rd_evt), .wr_evt(wr_evt), .wr_bit(wr_bit)
    );

    skc_key_matcher match_i (
        .clk(clk), .rst_n(rst_n),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .wr_bit(wr_bit),
        .xfer_done(xfer_done), .phase(phase), .unlock(unlock)
    );

    assign in_xfer = (phase == PH_XFER);

    skc_xfer_shifter shift_i (
        .clk(clk), .rst_n(rst_n),
        .start(unlock), .active(in_xfer),
        .rd_evt(rd_evt), .wr_evt(wr_evt), .wr_bit(wr_bit),
        .time_in(tk_time_in), .d0_out(bus_d0_out), .done(xfer_done),
        .wr_en(tk_wr_en), .wr_idx(tk_wr_idx), .wr_data(tk_wr_data)
    );

    assign mem_en    = !in_xfer;
    assign bus_d0_oe = in_xfer && rd_level;

    // R5
    // drive_excl_chk
    drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d0_oe |-> !mem_en);
    // R8
    // commit_in_window_chk
    commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tk_wr_en |-> $past(in_xfer));
endmodule

// File: tb/serial_key_clock_port_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module serial_key_clock_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, d0 = 1'b0;
    logic [63:0] time_in = '0;
    logic        mem_en, d0_out, d0_oe, wr_en;
    logic [2:0]  wr_idx;
    logic [7:0]  wr_data;

    int tests = 0;
    int fails = 0;
    int wr_count = 0;
    logic [7:0] model_regs [8];
    logic       written [8];

    always #5 clk = ~clk;

    serial_key_clock_port dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_ce_n(ce_n), .bus_oe_n(oe_n), .bus_we_n(we_n), .bus_d0_in(d0),
        .tk_time_in(time_in), .mem_en(mem_en), .bus_d0_out(d0_out),
        .bus_d0_oe(d0_oe), .tk_wr_en(wr_en), .tk_wr_idx(wr_idx), .tk_wr_data(wr_data)
    );

    // Monitor of register commit pulses.
    always @(posedge clk) begin
        if (rst_n && wr_en) begin
            wr_count++;
            model_regs[wr_idx] = wr_data;
            written[wr_idx]    = 1'b1;
        end
    end

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic key_bit(int i);
        logic [7:0] b;
        case ((i / 8) % 4)
            0: b = 8'hC5;
            1: b = 8'h3A;
            2: b = 8'hA3;
            default: b = 8'h5C;
        endcase
        return b[i % 8];
    endfunction

    task automatic hold(); repeat (4) @(negedge clk); endtask

    task automatic bus_write(logic v);
        d0 = v; ce_n = 1'b0; we_n = 1'b0; hold();
        we_n = 1'b1; ce_n = 1'b1; hold();
    endtask

    task automatic bus_read(output logic q, output logic oe);
        ce_n = 1'b0; oe_n = 1'b0; hold();
        q = d0_out; oe = d0_oe;
        oe_n = 1'b1; ce_n = 1'b1; hold();
    endtask

    task automatic arm();
        logic q, oe;
        bus_read(q, oe);
    endtask

    // Sends key bits from..to; returns 1 if mem_en ever dropped before the last.
    task automatic send_key(int from, int to, output logic dropped);
        dropped = 1'b0;
        for (int i = from; i <= to; i++) begin
            bus_write(key_bit(i));
            if (i < to && mem_en !== 1'b1) dropped = 1'b1;
        end
    endtask

    task automatic read_window(int n, output logic [63:0] got, output logic oe_bad);
        got = '0; oe_bad = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic q, oe;
            bus_read(q, oe);
            got[i] = q;
            if (oe !== 1'b1) oe_bad = 1'b1;
        end
    endtask

    task automatic t_reset();
        chk("R1 mem_en after reset", mem_en, 1);
        chk("R1 oe after reset", d0_oe, 0);
        chk("R1 no commits after reset", wr_count, 0);
    endtask

    task automatic t_no_arm();
        logic dr;
        send_key(0, 63, dr);
        chk("R1 key without read stays locked", mem_en, 1);
    endtask

    task automatic t_unlock_read();
        logic dr, ob;
        logic [63:0] got;
        time_in = 64'h0123_4567_89AB_CDEF;
        arm();
        send_key(0, 63, dr);
        chk("R5 mem_en during key", dr, 0);
        chk("R5 mem_en after 64th key write", mem_en, 0);
        chk("R2 unlocked", mem_en, 0);
        chk("R6 oe idle in window", d0_oe, 0);
        time_in = 64'hFFFF_0000_FFFF_0000;
        read_window(64, got, ob);
        chk("R6 oe during reads", ob, 0);
        chk("R7 snapshot bits", got, 64'h0123_4567_89AB_CDEF);
        chk("R10 memory restored", mem_en, 1);
    endtask

    task automatic t_write_regs();
        logic dr;
        logic [63:0] w = 64'hDEAD_BEEF_1357_9BDF;
        int base = wr_count;
        for (int k = 0; k < 8; k++) written[k] = 1'b0;
        arm();
        send_key(0, 63, dr);
        for (int i = 0; i < 64; i++) bus_write(w[i]);
        chk("R8 eight commits", wr_count - base, 8);
        for (int k = 0; k < 8; k++)
            chk("R8 committed byte", {written[k], model_regs[k]}, {1'b1, w[8*k +: 8]});
        chk("R10 memory restored after writes", mem_en, 1);
    endtask

    task automatic t_partial();
        logic dr, q, oe;
        int base = wr_count;
        for (int k = 0; k < 8; k++) written[k] = 1'b0;
        arm();
        send_key(0, 63, dr);
        for (int i = 0; i < 64; i++) begin
            if (i == 2 || i == 5) bus_read(q, oe);
            else bus_write(i[0]);
        end
        chk("R8 mixed group skipped", wr_count - base, 7);
        chk("R8 reg0 not written", written[0], 0);
        chk("R8 reg1 data", model_regs[1], 8'hAA);
    endtask

    task automatic t_mismatch();
        logic dr;
        logic [63:0] got;
        logic ob;
        arm();
        send_key(0, 9, dr);
        bus_write(~key_bit(10));
        send_key(10, 63, dr);
        chk("R3 frozen after mismatch", mem_en, 1);
        send_key(0, 63, dr);
        chk("R3 frozen ignores full key", mem_en, 1);
        arm();
        send_key(0, 63, dr);
        chk("R3 read recovers from freeze", mem_en, 0);
        read_window(64, got, ob);
    endtask

    task automatic t_abort();
        logic dr, ob;
        logic [63:0] got;
        arm();
        send_key(0, 19, dr);
        arm();
        send_key(20, 63, dr);
        chk("R4 read restarts pointer", mem_en, 1);
        arm();
        send_key(0, 29, dr);
        arm();
        send_key(0, 63, dr);
        chk("R4 full key after abort unlocks", mem_en, 0);
        read_window(64, got, ob);
    endtask

    task automatic t_ce_ignored();
        logic dr, ob, q, oe;
        logic [63:0] got;
        time_in = 64'h5A5A_C3C3_0F0F_9966;
        arm();
        send_key(0, 29, dr);
        for (int i = 0; i < 3; i++) begin
            d0 = ~key_bit(30); we_n = 1'b0; hold(); we_n = 1'b1; hold();
            oe_n = 1'b0; hold(); oe_n = 1'b1; hold();
        end
        send_key(30, 63, dr);
        chk("R9 ce-less strobes ignored in match", mem_en, 0);
        for (int i = 0; i < 5; i++) begin
            oe_n = 1'b0; hold(); oe_n = 1'b1; hold();
        end
        read_window(63, got, ob);
        chk("R9 window still open after 63", mem_en, 0);
        bus_read(q, oe);
        got[63] = q;
        chk("R9 ce-less strobes ignored in window", got, 64'h5A5A_C3C3_0F0F_9966);
        chk("R10 closed after 64th", mem_en, 1);
    endtask

    task automatic t_rearm();
        logic dr;
        send_key(0, 63, dr);
        chk("R10 new read required", mem_en, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_no_arm();
        t_unlock_read();
        t_rearm();
        t_write_regs();
        t_partial();
        t_mismatch();
        t_abort();
        t_ce_ignored();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule